// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns bytes into asynchronous serial frames on a single output line that rests at the mark (high) level. A byte arrives through a valid/ready handshake and waits in a one-entry holding register until the shift engine is free. The engine then sends a low start bit, the data bits starting with the least significant, an optional parity bit and a stop period. Each bit lasts sixteen ticks of an oversampling tick, and that tick fires once every `baud_div` clock cycles. With a 1.8432 MHz clock, a divisor of 115200 divided by the baud rate gives that rate.

The frame shape comes from an 8-bit line control byte. The control byte sets the word length from five to eight bits and chooses one stop bit or the longer stop period. It also sets the parity mode: off, even, odd, forced mark or forced space. A break bit drives the line to space at once, and a frame already on the line is dropped. The control byte and the divisor are captured when a frame starts, so changing them during a frame has no effect on that frame. The break bit is the exception and acts on the next clock. Two flags report that the holding register can take a byte and that the whole transmitter is idle.

Top module: `uart_frame_tx`

## Requirements
- R1: After a synchronous active-low reset, `ser_out` is 1, `hold_empty` is 1, `tx_ready` is 1 and `xmit_empty` is 1.
- R2: A frame is a 0 start bit followed by N data bits sent LSB first, where `line_ctrl[1:0]` = 0,1,2,3 gives N = 5,6,7,8. Every start, data and parity bit lasts 16*D clock cycles, where D is `baud_div` and a divisor of 0 acts as 1.
- R3: The stop period is at level 1. With `line_ctrl[2]` = 0 it lasts 16*D cycles. With `line_ctrl[2]` = 1 it lasts 24*D cycles for 5-bit words and 32*D cycles for 6, 7 and 8-bit words.
- R4: With `line_ctrl[3]` = 1 and `line_ctrl[5]` = 0, a parity bit goes between the last data bit and the stop period. It gives an even count of ones over data plus parity when `line_ctrl[4]` = 1 and an odd count when `line_ctrl[4]` = 0. With `line_ctrl[3]` = 0 no parity bit is sent.
- R5: With `line_ctrl[3]` = 1 and `line_ctrl[5]` = 1, the parity bit is the constant inverse of `line_ctrl[4]`: control 0x28 sends 1 and control 0x38 sends 0.
- R6: One cycle after `line_ctrl[6]` is sampled high, `ser_out` is 0. It stays 0 for as long as the bit stays high. A frame in progress is dropped, not resumed.
- R7: A byte accepted while break is set stays in the holding register. When break clears, the line shows one idle cycle at 1 and then the byte is sent as a complete frame.
- R8: A byte is accepted on a clock edge where `tx_valid` and `tx_ready` are both high, and `tx_ready` always equals `hold_empty`. The held byte moves into the shift engine on the next edge where the engine is idle or finishing its stop period. Back-to-back frames therefore have no idle gap.
- R9: `hold_empty` is 1 whenever the holding register is free, including while a frame is shifting. `xmit_empty` is 1 only when the holding register is free and no frame is in progress.
- R10: `line_ctrl` bits other than break, and `baud_div`, are captured on the edge where a frame starts. Changes during the frame do not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_data | input | 8 | Byte offered for transmission |
| tx_valid | input | 1 | `tx_data` is valid |
| tx_ready | output | 1 | Holding register can accept a byte |
| line_ctrl | input | 8 | Frame format and break control |
| baud_div | input | 16 | Clock cycles per oversampling tick |
| ser_out | output | 1 | Serial line, idles high |
| hold_empty | output | 1 | Holding register free |
| xmit_empty | output | 1 | Holding register free and shift engine idle |

## Verification
The assertions take some things as given about the inputs. `line_ctrl` holds a defined value during reset and in the cycle reset is released, and `tx_valid` is never X. They also accept that the break bit may change on any cycle. The stimulus drives all inputs at the falling edge and keeps them at defined values from time zero. It holds break low through reset and raises and drops break only after reset. This keeps each break check inside the window the assertions cover. Divisors stay small, so every frame shape, including the 1.5 stop period and divisor zero, finishes in a few hundred cycles.

// File: rtl/uart_tx_pkg.sv
// Shared types for the serial transmitter: engine states and the decoded
// frame format. Assumes at most 8 data bits per word.
package uart_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } tx_state_e;

    typedef enum logic [1:0] {
        STOP_ONE,
        STOP_ONE_HALF,
        STOP_TWO
    } stop_len_e;

    typedef struct packed {
        logic [1:0] len_sel;    // 0..3 -> shortest..longest word
        logic       par_en;
        logic       par_stick;
        logic       par_even;
        stop_len_e  stop_len;
    } frame_cfg_t;

endpackage

// File: rtl/uart_cfg_decode.sv
// Decodes the line control byte into a frame format and a break request.
// Purely combinational; the caller decides when the result is captured.
module uart_cfg_decode
    import uart_tx_pkg::*;
(
    input  logic [7:0]  line_ctrl,
    output frame_cfg_t  cfg,
    output logic        brk
);
    localparam int B_STB   = 2;
    localparam int B_PEN   = 3;
    localparam int B_EVEN  = 4;
    localparam int B_STICK = 5;
    localparam int B_BRK   = 6;

    logic unused_top_bit;
    assign unused_top_bit = line_ctrl[7];

    // Map control fields onto the format struct.
    always_comb begin
        cfg.len_sel   = line_ctrl[1:0];
        cfg.par_en    = line_ctrl[B_PEN];
        cfg.par_stick = line_ctrl[B_STICK];
        cfg.par_even  = line_ctrl[B_EVEN];
        if (!line_ctrl[B_STB])
            cfg.stop_len = STOP_ONE;
        else if (line_ctrl[1:0] == 2'b00)
            cfg.stop_len = STOP_ONE_HALF;
        else
            cfg.stop_len = STOP_TWO;
    end

    assign brk = line_ctrl[B_BRK];

endmodule

// File: rtl/uart_baud_tick.sv
// Oversampling tick generator: one-cycle pulse every DIV clocks while run
// is high; the count is cleared whenever run is low. DIV of 0 acts as 1.
module uart_baud_tick #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] lim;

    assign lim  = (div == '0) ? '0 : div - DIV_W'(1);
    assign tick = run && (cnt == lim);

    // Count clocks within one tick period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            cnt <= '0;
        else if (cnt == lim)
            cnt <= '0;
        else
            cnt <= cnt + DIV_W'(1);
    end

endmodule

// File: rtl/uart_hold_reg.sv
// Single-entry holding register between the handshake and the shifter.
// Assumes take is only raised while full is high.
module uart_hold_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              take,
    output logic [DATA_W-1:0] held_data,
    output logic              full
);
    assign in_ready = !full;

    // Fill on accept, drain when the shifter takes the byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full      <= 1'b0;
            held_data <= '0;
        end else if (take) begin
            full <= 1'b0;
        end else if (in_valid && !full) begin
            full      <= 1'b1;
            held_data <= in_data;
        end
    end

endmodule

// File: rtl/uart_shift_core.sv
// Frame shift engine. Captures format and divisor at frame start, walks
// start/data/parity/stop states on oversampling ticks, and drops the frame
// while break is registered high. Assumes tick comes from a generator
// driven by run and div_q.
module uart_shift_core
    import uart_tx_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int DIV_W      = 16,
    parameter int OVERSAMPLE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold_full,
    input  logic [DATA_W-1:0] hold_data,
    input  frame_cfg_t        cfg,
    input  logic [DIV_W-1:0]  div,
    input  logic              brk,
    input  logic              tick,
    output logic              take,
    output logic              run,
    output logic [DIV_W-1:0]  div_q,
    output logic              busy,
    output logic              ser_out
);
    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam int TCW   = $clog2(2 * OVERSAMPLE);
    localparam int MIN_W = DATA_W - 3;

    tx_state_e         state;
    frame_cfg_t        cfg_q;
    logic [DATA_W-1:0] sh;
    logic [CNT_W-1:0]  bit_idx;
    logic [TCW-1:0]    tick_cnt;
    logic              par_q;
    logic              brk_q;

    logic [CNT_W-1:0]  nbits_new;
    logic [CNT_W-1:0]  nbits_q;
    logic              par_new;
    logic [TCW-1:0]    limit;
    logic              bit_end;
    logic              frame_end;
    logic              line;

    assign nbits_new = CNT_W'(MIN_W) + CNT_W'(cfg.len_sel);
    assign nbits_q   = CNT_W'(MIN_W) + CNT_W'(cfg_q.len_sel);

    // Parity of the incoming byte over the selected word length.
    always_comb begin
        logic x;
        x = 1'b0;
        for (int i = 0; i < DATA_W; i++)
            if (CNT_W'(i) < nbits_new)
                x = x ^ hold_data[i];
        if (cfg.par_stick)
            par_new = !cfg.par_even;
        else
            par_new = cfg.par_even ? x : !x;
    end

    // Tick limit of the current bit: stop period varies, others are fixed.
    always_comb begin
        limit = TCW'(OVERSAMPLE - 1);
        if (state == ST_STOP) begin
            case (cfg_q.stop_len)
                STOP_ONE_HALF: limit = TCW'(OVERSAMPLE + OVERSAMPLE / 2 - 1);
                STOP_TWO:      limit = TCW'(2 * OVERSAMPLE - 1);
                default:       limit = TCW'(OVERSAMPLE - 1);
            endcase
        end
    end

    assign bit_end   = tick && (tick_cnt == limit);
    assign frame_end = (state == ST_STOP) && bit_end;
    assign take      = hold_full && !brk_q && ((state == ST_IDLE) || frame_end);
    assign run       = (state != ST_IDLE);
    assign busy      = run;

    // Register the break request.
    always_ff @(posedge clk) begin
        if (!rst_n) brk_q <= 1'b0;
        else        brk_q <= brk;
    end

    // Frame sequencing, capture at start and abort on break.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cfg_q    <= '0;
            sh       <= '0;
            bit_idx  <= '0;
            tick_cnt <= '0;
            par_q    <= 1'b0;
            div_q    <= '0;
        end else if (brk_q) begin
            state    <= ST_IDLE;
            tick_cnt <= '0;
        end else if (take) begin
            state    <= ST_START;
            cfg_q    <= cfg;
            sh       <= hold_data;
            bit_idx  <= '0;
            tick_cnt <= '0;
            par_q    <= par_new;
            div_q    <= div;
        end else if (run && tick) begin
            if (!bit_end) begin
                tick_cnt <= tick_cnt + TCW'(1);
            end else begin
                tick_cnt <= '0;
                case (state)
                    ST_START: begin
                        state   <= ST_DATA;
                        bit_idx <= '0;
                    end
                    ST_DATA: begin
                        sh      <= sh >> 1;
                        bit_idx <= bit_idx + CNT_W'(1);
                        if (bit_idx == nbits_q - CNT_W'(1))
                            state <= cfg_q.par_en ? ST_PARITY : ST_STOP;
                    end
                    ST_PARITY: state <= ST_STOP;
                    default:   state <= ST_IDLE;
                endcase
            end
        end
    end

    // Line level for the current state.
    always_comb begin
        case (state)
            ST_START:  line = 1'b0;
            ST_DATA:   line = sh[0];
            ST_PARITY: line = par_q;
            default:   line = 1'b1;
        endcase
    end

    assign ser_out = !brk_q && line;

endmodule

// File: rtl/uart_frame_tx.sv
// Top of the serial transmitter: holding register, format decode, tick
// generator and shift engine. Assumes inputs are synchronous to clk.
module uart_frame_tx
    import uart_tx_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int DIV_W      = 16,
    parameter int OVERSAMPLE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    input  logic [7:0]        line_ctrl,
    input  logic [DIV_W-1:0]  baud_div,
    output logic              ser_out,
    output logic              hold_empty,
    output logic              xmit_empty
);
    frame_cfg_t        cfg;
    logic              brk;
    logic              take;
    logic              full;
    logic [DATA_W-1:0] held;
    logic              run;
    logic              tick;
    logic              busy;
    logic [DIV_W-1:0]  div_q;

    uart_cfg_decode u_dec (
        .line_ctrl (line_ctrl),
        .cfg       (cfg),
        .brk       (brk)
    );

    uart_hold_reg #(.DATA_W(DATA_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_data   (tx_data),
        .in_valid  (tx_valid),
        .in_ready  (tx_ready),
        .take      (take),
        .held_data (held),
        .full      (full)
    );

    uart_baud_tick #(.DIV_W(DIV_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .div   (div_q),
        .tick  (tick)
    );

    uart_shift_core #(
        .DATA_W     (DATA_W),
        .DIV_W      (DIV_W),
        .OVERSAMPLE (OVERSAMPLE)
    ) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold_full (full),
        .hold_data (held),
        .cfg       (cfg),
        .div       (baud_div),
        .brk       (brk),
        .tick      (tick),
        .take      (take),
        .run       (run),
        .div_q     (div_q),
        .busy      (busy),
        .ser_out   (ser_out)
    );

    assign hold_empty = !full;
    assign xmit_empty = !full && !busy;

endmodule

// File: rtl/uart_frame_tx_chk.sv
// Port-level property checker for the serial transmitter, bound to the top.
module uart_frame_tx_chk #(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] tx_data,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic [7:0]        line_ctrl,
    input logic [DIV_W-1:0]  baud_div,
    input logic              ser_out,
    input logic              hold_empty,
    input logic              xmit_empty
);
    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (ser_out && hold_empty && xmit_empty));

    a_r9_empty_implies_hold: assert property (@(posedge clk) disable iff (!rst_n)
        xmit_empty |-> hold_empty);

    a_r6_break_space: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(line_ctrl[6])) |-> !ser_out);

    a_r8_accept_fills: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> !hold_empty);

    a_r7_hold_during_break: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !hold_empty && line_ctrl[6] && $past(line_ctrl[6]))
        |=> !hold_empty);

endmodule

bind uart_frame_tx uart_frame_tx_chk #(.DATA_W(DATA_W), .DIV_W(DIV_W)) chk_i (.*);

// File: tb/uart_frame_tx_tb_top.sv
// Bench: behavioural frame model built from queues of line segments,
// compared with the design on every falling edge.
module uart_frame_tx_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  tx_data = 8'h00;
    logic        tx_valid = 1'b0;
    logic        tx_ready;
    logic [7:0]  line_ctrl = 8'h03;
    logic [15:0] baud_div = 16'd1;
    logic        ser_out;
    logic        hold_empty;
    logic        xmit_empty;

    int    checks = 0;
    int    errors = 0;
    int    cycles = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    uart_frame_tx dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_data    (tx_data),
        .tx_valid   (tx_valid),
        .tx_ready   (tx_ready),
        .line_ctrl  (line_ctrl),
        .baud_div   (baud_div),
        .ser_out    (ser_out),
        .hold_empty (hold_empty),
        .xmit_empty (xmit_empty)
    );

    // Reference model state
    int   q_lvl[$];
    int   q_len[$];
    int   seg_left = 0;
    bit   m_busy = 0;
    bit   m_full = 0;
    bit   m_brk = 0;
    bit   m_started = 0;
    logic [7:0] m_data = 8'h00;

    function automatic void build_frame(logic [7:0] d, logic [7:0] lc, logic [15:0] dv);
        int n, dd, par, ones, st;
        dd = (dv == 0) ? 1 : int'(dv);
        n = 5 + int'(lc[1:0]);
        q_lvl.delete(); q_len.delete();
        q_lvl.push_back(0); q_len.push_back(16 * dd);
        ones = 0;
        for (int i = 0; i < n; i++) begin
            q_lvl.push_back(int'(d[i])); q_len.push_back(16 * dd);
            ones += int'(d[i]);
        end
        if (lc[3]) begin
            if (lc[5]) par = lc[4] ? 0 : 1;
            else if (lc[4]) par = ones % 2;
            else par = 1 - (ones % 2);
            q_lvl.push_back(par); q_len.push_back(16 * dd);
        end
        if (!lc[2]) st = 16; else if (n == 5) st = 24; else st = 32;
        q_lvl.push_back(1); q_len.push_back(st * dd);
        seg_left = q_len[0];
    endfunction

    // Advance the model one clock.
    always @(posedge clk) begin
        bit acc, brk_pre, full_pre;
        cycles++;
        if (!rst_n) begin
            q_lvl.delete(); q_len.delete();
            m_busy = 0; m_full = 0; m_brk = 0; m_started = 1;
        end else begin
            acc = tx_valid && !m_full;
            brk_pre = m_brk;
            full_pre = m_full;
            if (brk_pre) begin
                q_lvl.delete(); q_len.delete(); m_busy = 0;
            end else if (m_busy) begin
                seg_left--;
                if (seg_left == 0) begin
                    void'(q_lvl.pop_front()); void'(q_len.pop_front());
                    if (q_lvl.size() == 0) m_busy = 0;
                    else seg_left = q_len[0];
                end
            end
            if (!brk_pre && !m_busy && full_pre) begin
                build_frame(m_data, line_ctrl, baud_div);
                m_busy = 1; m_full = 0;
            end
            if (acc) begin m_full = 1; m_data = tx_data; end
            m_brk = line_ctrl[6];
        end
    end

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cycles);
        end
    endtask

    // Compare every output with the model away from the active edge.
    always @(negedge clk) begin
        int e_ser;
        if (m_started && rst_n) begin
            e_ser = m_brk ? 0 : (m_busy ? q_lvl[0] : 1);
            check(cur_req, "ser_out", int'(ser_out), e_ser);
            check(cur_req, "hold_empty", int'(hold_empty), int'(!m_full));
            check("R8", "tx_ready", int'(tx_ready), int'(!m_full));
            check("R9", "xmit_empty", int'(xmit_empty), int'(!m_full && !m_busy));
        end
    end

    task automatic send(logic [7:0] b);
        @(negedge clk);
        while (!tx_ready) @(negedge clk);
        tx_valid = 1'b1; tx_data = b;
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic wait_idle();
        repeat (2) @(negedge clk);
        while (!xmit_empty) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic frame(string req, logic [7:0] lc, logic [15:0] dv, logic [7:0] b);
        cur_req = req;
        @(negedge clk);
        line_ctrl = lc; baud_div = dv;
        send(b);
        wait_idle();
    endtask

    // Watchdog
    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=0", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "reset ser_out", int'(ser_out), 1);
        check("R1", "reset hold_empty", int'(hold_empty), 1);
        check("R1", "reset xmit_empty", int'(xmit_empty), 1);

        frame("R2", 8'h03, 16'd1, 8'hA5);       // 8N1
        frame("R2", 8'h01, 16'd0, 8'h3C);       // 6N1, divisor 0
        frame("R3", 8'h04, 16'd2, 8'h15);       // 5 bits, 1.5 stop
        frame("R3", 8'h07, 16'd1, 8'h81);       // 8 bits, 2 stop
        frame("R4", 8'h1A, 16'd1, 8'h55);       // 7 even
        frame("R4", 8'h0B, 16'd1, 8'h01);       // 8 odd
        frame("R4", 8'h19, 16'd3, 8'h2B);       // 6 even
        frame("R5", 8'h2B, 16'd1, 8'h00);       // mark
        frame("R5", 8'h3B, 16'd1, 8'hFF);       // space

        // R8 back-to-back, R9 holding free during a shift
        cur_req = "R8";
        line_ctrl = 8'h03; baud_div = 16'd1;
        send(8'h11);
        repeat (3) @(negedge clk);
        check("R9", "hold free while shifting", int'(hold_empty), 1);
        check("R9", "not empty while shifting", int'(xmit_empty), 0);
        send(8'h22);
        send(8'h33);
        wait_idle();

        // R10 format and divisor changes during a frame are ignored
        cur_req = "R10";
        line_ctrl = 8'h03; baud_div = 16'd2;
        send(8'hC6);
        repeat (20) @(negedge clk);
        line_ctrl = 8'h0C; baud_div = 16'd1;
        wait_idle();

        // R6 break mid-frame, R7 byte held through break
        cur_req = "R6";
        line_ctrl = 8'h03; baud_div = 16'd1;
        send(8'hF0);
        repeat (40) @(negedge clk);
        line_ctrl = 8'h43;
        @(negedge clk);
        @(negedge clk);
        check("R6", "break forces space", int'(ser_out), 0);
        cur_req = "R7";
        send(8'h5A);
        repeat (20) @(negedge clk);
        check("R7", "byte held in break", int'(hold_empty), 0);
        check("R7", "line space in break", int'(ser_out), 0);
        line_ctrl = 8'h03;
        @(negedge clk);
        check("R7", "idle cycle after break", int'(ser_out), 1);
        wait_idle();

        // R6 single-cycle break during a frame
        cur_req = "R6";
        send(8'h0F);
        repeat (30) @(negedge clk);
        line_ctrl = 8'h43;
        @(negedge clk);
        line_ctrl = 8'h03;
        wait_idle();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule